// File: doc/BRIEF.md
# Soft-Start and Voltage-Step Sequencer

This block is the digital control sequencer of a step-down regulator whose output voltage is selected by a 7-bit code. When the enable level rises, it runs a soft-start ramp on the reference. It then raises a soft-start-done flag. After 1.7 times the soft-start time it raises an interface-ready flag. Only then does it accept new voltage codes from the serial interface. Until the first code arrives, the reference code stays at the default value, code 0, which corresponds to the 0.6 V feedback target. Every time constant is a parameter counted in clock ticks.

Each accepted code does three things. It becomes the target of the reference, which slews toward it one code step per tick interval. It starts a forced continuous-conduction window of fixed length. It masks the power-good output for that same window. During the mask, power-good keeps the value it had just before the code arrived, so the step cannot raise a false fault. A second code that arrives inside the window restarts it. Power-good itself comes from four window comparator flags, with separate trip and clear points on the low side and on the high side. Dropping enable clears the whole sequence at the next clock edge.

The code input is a valid/ready port. The sequencer holds ready low until interface-ready is set. A code is taken on a rising clock edge where valid and ready are both high. The sender must hold valid and the code stable until that edge. The block never drops a code that has been offered and never takes one while ready is low.

Top module: `vid_ref_sequencer`

## Requirements
- R1: After enable rises, `ss_ramp_o` starts at 0. It rises by one every SS_TICKS/(2^RAMP_W-1) cycles and reaches all-ones after SS_TICKS cycles. SS_TICKS must be a multiple of 2^RAMP_W-1.
- R2: `ss_done_o` is 0 until enable has been high for SS_TICKS rising edges, and it is 1 from that edge onward.
- R3: `if_ready_o` rises once enable has been high for floor(17*SS_TICKS/10) edges, never before `ss_done_o`.
- R4: Until a code has been accepted since enable rose, `ref_code_o` equals DEF_CODE (default 0).
- R5: `code_ready_o` equals `if_ready_o`. A code is accepted only on an edge where `code_valid_i` and `code_ready_o` are both 1. Codes offered while ready is 0 wait without effect.
- R6: `ref_code_o` moves toward the accepted code by exactly one step every SLEW_TICKS cycles, either up or down. Counted from an accepted code while the reference is settled, it takes its first step SLEW_TICKS cycles after the accepting edge and arrives after SLEW_TICKS times the distance.
- R7: `fccm_o` is 1 for exactly FCCM_TICKS cycles, starting at the accepting edge. A code accepted while `fccm_o` is 1 restarts the full count from its own edge.
- R8: Low side of the window. FB below the 80% trip (`fb_lt_uv_trip_i`=1) makes power-good bad at the next edge. It becomes good again only when FB is above the 85% clear point (`fb_gt_uv_clear_i`=1). Between the two points it keeps its state.
- R9: High side of the window. FB above the 125% trip (`fb_gt_ov_trip_i`=1) makes power-good bad. It becomes good again only when FB is below the 120% clear point (`fb_lt_ov_clear_i`=1). Between the two points it keeps its state.
- R10: While `fccm_o` is 1, `pgood_o` keeps the value it had before the accepting edge. At the edge where `fccm_o` falls, `pgood_o` takes the current window state.
- R11: At the first edge with enable low, the ramp, reference code (back to DEF_CODE), done, ready, forced-CCM and power-good all clear. The low side restarts as bad, and a new enable restarts the ramp from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Regulator enable level |
| code_valid_i | input | 1 | A new voltage code is offered |
| code_ready_o | output | 1 | Sequencer can take a code |
| code_i | input | CODE_W | Offered voltage code |
| fb_lt_uv_trip_i | input | 1 | FB below 80% of target |
| fb_gt_uv_clear_i | input | 1 | FB above 85% of target |
| fb_gt_ov_trip_i | input | 1 | FB above 125% of target |
| fb_lt_ov_clear_i | input | 1 | FB below 120% of target |
| ref_code_o | output | CODE_W | Reference code to the DAC |
| ss_ramp_o | output | RAMP_W | Soft-start ramp level, fraction of full reference |
| ss_done_o | output | 1 | Soft-start finished |
| if_ready_o | output | 1 | Serial interface may be used |
| fccm_o | output | 1 | Force continuous-conduction mode |
| pgood_o | output | 1 | Masked power-good |

## Verification
Every output is a register, so a result is due at the first edge that sees its stimulus. For a stimulus driven after edge n, the result is due at edge n+1. The one exception is the slew, which is due SLEW_TICKS times the step count after the accepting edge. Ramp, done and ready are due at fixed edge counts after enable, and the forced-CCM window closes exactly FCCM_TICKS edges after acceptance. The bench stamps each expected value with the edge number at which it is due. It compares the value half a clock after that edge. It also checks the edge just before, where the old value must still hold, so an early change is caught as well as a late one.

// File: rtl/vid_seq_pkg.sv
package vid_seq_pkg;

  // Window comparator flags as delivered by the analog front end.
  typedef struct packed {
    logic lt_uv_trip;   // FB below the low trip point
    logic gt_uv_clear;  // FB above the low clear point
    logic gt_ov_trip;   // FB above the high trip point
    logic lt_ov_clear;  // FB below the high clear point
  } fb_flags_t;

  // Hysteresis state of the two sides of the window.
  typedef struct packed {
    logic low_bad;
    logic high_bad;
  } pg_state_t;

  localparam pg_state_t PG_START = '{low_bad: 1'b1, high_bad: 1'b0};

  // Trip has priority over clear; between the two points a side keeps its state.
  function automatic pg_state_t pg_step(input pg_state_t cur, input fb_flags_t f);
    pg_state_t nxt;
    nxt = cur;
    if (f.lt_uv_trip)       nxt.low_bad  = 1'b1;
    else if (f.gt_uv_clear) nxt.low_bad  = 1'b0;
    if (f.gt_ov_trip)       nxt.high_bad = 1'b1;
    else if (f.lt_ov_clear) nxt.high_bad = 1'b0;
    return nxt;
  endfunction

endpackage

// File: rtl/vid_ss_timer.sv
module vid_ss_timer #(
  parameter int SS_TICKS = 124992,
  parameter int RAMP_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  output logic [RAMP_W-1:0] ramp_o,
  output logic              done_o,
  output logic              ready_o
);
  localparam int RAMP_MAX   = (1 << RAMP_W) - 1;
  localparam int STEP_TICKS = (SS_TICKS / RAMP_MAX < 1) ? 1 : SS_TICKS / RAMP_MAX;
  localparam int RDY_TICKS  = (SS_TICKS * 17) / 10;
  localparam int EL_W       = $clog2(RDY_TICKS + 1);
  localparam int STEP_W     = $clog2(STEP_TICKS + 1);
  localparam logic [EL_W-1:0]   SS_C      = EL_W'(SS_TICKS);
  localparam logic [EL_W-1:0]   RDY_C     = EL_W'(RDY_TICKS);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEP_TICKS - 1);
  localparam logic [RAMP_W-1:0] RAMP_TOP  = RAMP_W'(RAMP_MAX);

  logic [EL_W-1:0]   elapsed;
  logic [STEP_W-1:0] step_cnt;
  logic              done_q, ready_q;

  // Elapsed edges since enable, saturating at the interface-ready point.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              elapsed <= '0;
    else if (!en_i)          elapsed <= '0;
    else if (elapsed != RDY_C) elapsed <= elapsed + 1'b1;
  end

  // Ramp advances one level every STEP_TICKS edges until full scale.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_cnt <= '0;
      ramp_o   <= '0;
    end else if (!en_i) begin
      step_cnt <= '0;
      ramp_o   <= '0;
    end else if (ramp_o != RAMP_TOP) begin
      if (step_cnt == STEP_LAST) begin
        step_cnt <= '0;
        ramp_o   <= ramp_o + 1'b1;
      end else begin
        step_cnt <= step_cnt + 1'b1;
      end
    end
  end

  // Flags registered from the next elapsed value so they line up with it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      ready_q <= 1'b0;
    end else if (!en_i) begin
      done_q  <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      done_q  <= (elapsed + 1'b1 >= SS_C)  || done_q;
      ready_q <= (elapsed + 1'b1 >= RDY_C) || ready_q;
    end
  end

  assign done_o  = done_q;
  assign ready_o = ready_q;

endmodule

// File: rtl/vid_slew.sv
module vid_slew #(
  parameter int CODE_W     = 7,
  parameter int SLEW_TICKS = 125,
  parameter int FCCM_TICKS = 12500,
  parameter int DEF_CODE   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              take_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] ref_o,
  output logic              fccm_o,
  output logic              hold_next_o
);
  localparam int WIN_W = $clog2(FCCM_TICKS + 1);
  localparam logic [WIN_W-1:0]  WIN_LOAD = WIN_W'(FCCM_TICKS);
  localparam logic [CODE_W-1:0] DEF_C    = CODE_W'(DEF_CODE);

  logic [CODE_W-1:0] target;
  logic [WIN_W-1:0]  win_cnt, win_next;
  logic              step_now;

  // Forced-CCM window: loaded by each accepted code, counts down to zero.
  always_comb begin
    if (!en_i)             win_next = '0;
    else if (take_i)       win_next = WIN_LOAD;
    else if (win_cnt != '0) win_next = win_cnt - 1'b1;
    else                   win_next = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_cnt <= '0;
    else        win_cnt <= win_next;
  end

  assign fccm_o      = (win_cnt != '0);
  assign hold_next_o = (win_next != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      target <= DEF_C;
    else if (!en_i)  target <= DEF_C;
    else if (take_i) target <= code_i;
  end

  // Step pacing: a counter when steps are spaced, a direct step otherwise.
  generate
    if (SLEW_TICKS > 1) begin : g_paced
      localparam int SL_W = $clog2(SLEW_TICKS);
      localparam logic [SL_W-1:0] SL_LAST = SL_W'(SLEW_TICKS - 1);
      logic [SL_W-1:0] pace;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         pace <= '0;
        else if (!en_i || ref_o == target)  pace <= '0;
        else if (pace == SL_LAST)           pace <= '0;
        else                                pace <= pace + 1'b1;
      end
      assign step_now = (ref_o != target) && (pace == SL_LAST);
    end else begin : g_direct
      assign step_now = (ref_o != target);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ref_o <= DEF_C;
    else if (!en_i)    ref_o <= DEF_C;
    else if (step_now) ref_o <= (ref_o < target) ? ref_o + 1'b1 : ref_o - 1'b1;
  end

endmodule

// File: rtl/vid_pg_window.sv
module vid_pg_window
  import vid_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en_i,
  input  fb_flags_t flags_i,
  input  logic      hold_i,
  output logic      ok_o,
  output logic      pgood_o
);
  pg_state_t st, st_next;

  always_comb begin
    st_next = en_i ? pg_step(st, flags_i) : PG_START;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= PG_START;
    else        st <= st_next;
  end

  assign ok_o = !st.low_bad && !st.high_bad;

  // Masked output: frozen while the window counter stays non-zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pgood_o <= 1'b0;
    else if (!en_i)   pgood_o <= 1'b0;
    else if (!hold_i) pgood_o <= !st_next.low_bad && !st_next.high_bad;
  end

endmodule

// File: rtl/vid_ref_sequencer.sv
module vid_ref_sequencer
  import vid_seq_pkg::*;
#(
  parameter int CODE_W     = 7,
  parameter int RAMP_W     = 5,
  parameter int SS_TICKS   = 124992,
  parameter int FCCM_TICKS = 12500,
  parameter int SLEW_TICKS = 125,
  parameter int DEF_CODE   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              code_valid_i,
  output logic              code_ready_o,
  input  logic [CODE_W-1:0] code_i,
  input  logic              fb_lt_uv_trip_i,
  input  logic              fb_gt_uv_clear_i,
  input  logic              fb_gt_ov_trip_i,
  input  logic              fb_lt_ov_clear_i,
  output logic [CODE_W-1:0] ref_code_o,
  output logic [RAMP_W-1:0] ss_ramp_o,
  output logic              ss_done_o,
  output logic              if_ready_o,
  output logic              fccm_o,
  output logic              pgood_o
);
  fb_flags_t flags;
  logic      take;
  logic      hold_next;
  logic      pg_ok;

  assign flags = '{lt_uv_trip:  fb_lt_uv_trip_i,
                   gt_uv_clear: fb_gt_uv_clear_i,
                   gt_ov_trip:  fb_gt_ov_trip_i,
                   lt_ov_clear: fb_lt_ov_clear_i};

  assign code_ready_o = if_ready_o;
  assign take         = code_valid_i && code_ready_o;

  vid_ss_timer #(.SS_TICKS(SS_TICKS), .RAMP_W(RAMP_W)) u_ss (
    .clk(clk), .rst_n(rst_n), .en_i(en_i),
    .ramp_o(ss_ramp_o), .done_o(ss_done_o), .ready_o(if_ready_o)
  );

  vid_slew #(.CODE_W(CODE_W), .SLEW_TICKS(SLEW_TICKS),
             .FCCM_TICKS(FCCM_TICKS), .DEF_CODE(DEF_CODE)) u_slew (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .take_i(take), .code_i(code_i),
    .ref_o(ref_code_o), .fccm_o(fccm_o), .hold_next_o(hold_next)
  );

  vid_pg_window u_pg (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .flags_i(flags),
    .hold_i(hold_next), .ok_o(pg_ok), .pgood_o(pgood_o)
  );

endmodule

// File: rtl/vid_ref_sequencer_chk.sv
module vid_ref_sequencer_chk #(
  parameter int CODE_W   = 7,
  parameter int RAMP_W   = 5,
  parameter int DEF_CODE = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_i,
  input logic              code_valid_i,
  input logic              code_ready_o,
  input logic              fb_lt_uv_trip_i,
  input logic              fb_gt_ov_trip_i,
  input logic [CODE_W-1:0] ref_code_o,
  input logic [RAMP_W-1:0] ss_ramp_o,
  input logic              ss_done_o,
  input logic              if_ready_o,
  input logic              fccm_o,
  input logic              pgood_o,
  input logic              pg_ok
);
  localparam logic [RAMP_W-1:0] RAMP_TOP = '1;
  localparam logic [CODE_W-1:0] DEF_C    = CODE_W'(DEF_CODE);
  localparam logic [CODE_W-1:0] ONE      = CODE_W'(1);

  assert_ramp_full_at_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_done_o) |-> ss_ramp_o == RAMP_TOP);

  assert_done_before_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    if_ready_o |-> ss_done_o);

  assert_no_take_when_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !code_ready_o && !fccm_o) |=> !fccm_o);

  assert_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && $past(en_i)) |-> (ref_code_o == $past(ref_code_o)) ||
                              (ref_code_o == $past(ref_code_o) + ONE) ||
                              (ref_code_o == $past(ref_code_o) - ONE));

  assert_window_opens_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && code_valid_i && code_ready_o) |=> fccm_o);

  assert_low_trip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && fb_lt_uv_trip_i) |=> !pg_ok);

  assert_high_trip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && fb_gt_ov_trip_i) |=> !pg_ok);

  assert_pg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fccm_o && $past(en_i)) |-> $stable(pgood_o));

  assert_pg_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && $past(en_i) && !fccm_o) |-> pgood_o == pg_ok);

  assert_disable_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (ref_code_o == DEF_C && ss_ramp_o == '0 && !ss_done_o &&
               !if_ready_o && !fccm_o && !pgood_o));

endmodule

bind vid_ref_sequencer vid_ref_sequencer_chk #(
  .CODE_W(CODE_W), .RAMP_W(RAMP_W), .DEF_CODE(DEF_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .code_valid_i(code_valid_i),
  .code_ready_o(code_ready_o), .fb_lt_uv_trip_i(fb_lt_uv_trip_i),
  .fb_gt_ov_trip_i(fb_gt_ov_trip_i), .ref_code_o(ref_code_o),
  .ss_ramp_o(ss_ramp_o), .ss_done_o(ss_done_o), .if_ready_o(if_ready_o),
  .fccm_o(fccm_o), .pgood_o(pgood_o), .pg_ok(pg_ok)
);

// File: tb/tb_vid_ref_sequencer.sv
module tb_vid_ref_sequencer;
  localparam int CW = 7;
  localparam int RW = 3;
  localparam int SS = 70;
  localparam int STEP = 10;
  localparam int RDY = 119;
  localparam int FC = 20;
  localparam int SL = 4;

  typedef struct {
    int    due;
    int    sig;
    int    val;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic cvalid = 1'b0;
  logic [CW-1:0] code = '0;
  logic uvt = 1'b1, uvc = 1'b0, ovt = 1'b0, ovc = 1'b1;
  logic cready;
  logic [CW-1:0] refc;
  logic [RW-1:0] ramp;
  logic ssd, ifr, fccm, pg;

  int   cyc = 0;
  int   total = 0;
  int   bad = 0;
  int   cur_ref = 0;
  exp_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vid_ref_sequencer #(.CODE_W(CW), .RAMP_W(RW), .SS_TICKS(SS), .FCCM_TICKS(FC),
                      .SLEW_TICKS(SL), .DEF_CODE(0)) dut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .code_valid_i(cvalid), .code_ready_o(cready),
    .code_i(code), .fb_lt_uv_trip_i(uvt), .fb_gt_uv_clear_i(uvc),
    .fb_gt_ov_trip_i(ovt), .fb_lt_ov_clear_i(ovc), .ref_code_o(refc),
    .ss_ramp_o(ramp), .ss_done_o(ssd), .if_ready_o(ifr), .fccm_o(fccm), .pgood_o(pg)
  );

  function automatic int sample(int s);
    case (s)
      0: return int'(refc);
      1: return int'(ramp);
      2: return int'(ssd);
      3: return int'(ifr);
      4: return int'(fccm);
      5: return int'(pg);
      default: return int'(cready);
    endcase
  endfunction

  function automatic string sname(int s);
    case (s)
      0: return "ref_code"; 1: return "ss_ramp"; 2: return "ss_done";
      3: return "if_ready"; 4: return "fccm"; 5: return "pgood";
      default: return "code_ready";
    endcase
  endfunction

  task automatic check(string tag, int s, int exp);
    total++;
    if (sample(s) != exp) begin
      bad++;
      $display("FAIL %s %s at edge %0d: actual=%0d expected=%0d", tag, sname(s), cyc, sample(s), exp);
    end
  endtask

  task automatic expect_at(int due, int s, int v, string tag);
    exp_t e;
    e.due = due; e.sig = s; e.val = v; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compares every expectation half a clock after its due edge.
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        check(q[i].tag, q[i].sig, q[i].val);
        q.delete(i);
      end
    end
  end

  task automatic set_fb(logic a, logic b, logic c, logic d);
    uvt = a; uvc = b; ovt = c; ovc = d;
  endtask

  task automatic pg_step(logic a, logic b, logic c, logic d, int exp, string tag);
    set_fb(a, b, c, d);
    expect_at(cyc + 1, 5, exp, tag);
    repeat (2) @(negedge clk);
  endtask

  task automatic settle();
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Driver: offers a code, waits for the handshake, pushes the expected results.
  task automatic send_code(int t, bit full, output int h);
    int d;
    cvalid = 1'b1;
    code = CW'(t);
    while (!cready) @(negedge clk);
    h = cyc + 1;
    @(negedge clk);
    cvalid = 1'b0;
    expect_at(h + 1, 4, 1, "R7");
    if (full) begin
      expect_at(h + FC - 1, 4, 1, "R7");
      expect_at(h + FC, 4, 0, "R7");
      d = (t > cur_ref) ? t - cur_ref : cur_ref - t;
      if (d > 0) begin
        expect_at(h + SL - 1, 0, cur_ref, "R6");
        expect_at(h + SL, 0, (t > cur_ref) ? cur_ref + 1 : cur_ref - 1, "R6");
        expect_at(h + SL * d - 1, 0, (t > cur_ref) ? t - 1 : t + 1, "R6");
        expect_at(h + SL * d, 0, t, "R6");
      end
    end
    cur_ref = t;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired at edge %0d", cyc);
    finish_run();
  end

  initial begin
    int c0, h, h1, h2, n;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int s = 0; s < 7; s++) check("reset", s, 0);

    // Soft start (R1 R2 R3 R4)
    c0 = cyc;
    en = 1'b1;
    expect_at(c0 + STEP - 1, 1, 0, "R1");
    expect_at(c0 + STEP, 1, 1, "R1");
    expect_at(c0 + 3 * STEP, 1, 3, "R1");
    expect_at(c0 + SS - 1, 1, 6, "R1");
    expect_at(c0 + SS, 1, 7, "R1");
    expect_at(c0 + SS - 1, 2, 0, "R2");
    expect_at(c0 + SS, 2, 1, "R2");
    expect_at(c0 + RDY - 1, 3, 0, "R3");
    expect_at(c0 + RDY, 3, 1, "R3");
    expect_at(c0 + RDY - 1, 6, 0, "R5");
    expect_at(c0 + RDY, 6, 1, "R5");
    expect_at(c0 + 100, 0, 0, "R4");

    // Window hysteresis during the ramp (R8 R9)
    repeat (5) @(negedge clk);
    pg_step(0, 0, 0, 1, 0, "R8");
    pg_step(0, 1, 0, 1, 1, "R8");
    pg_step(0, 0, 0, 1, 1, "R8");
    pg_step(1, 0, 0, 1, 0, "R8");
    pg_step(0, 1, 0, 1, 1, "R8");
    pg_step(0, 1, 1, 0, 0, "R9");
    pg_step(0, 1, 0, 0, 0, "R9");
    pg_step(0, 1, 0, 1, 1, "R9");
    pg_step(0, 1, 0, 0, 1, "R9");
    pg_step(0, 1, 0, 1, 1, "R9");

    // Code offered early must wait for ready (R5)
    while (cyc < c0 + 50) @(negedge clk);
    expect_at(c0 + RDY, 4, 0, "R5");
    expect_at(c0 + RDY, 0, 0, "R5");
    send_code(40, 1'b1, h);
    total++;
    if (h != c0 + RDY + 1) begin
      bad++;
      $display("FAIL R5 accept edge: actual=%0d expected=%0d", h, c0 + RDY + 1);
    end

    // Power-good frozen while the window is open (R10)
    while (cyc < h + 3) @(negedge clk);
    set_fb(1, 0, 0, 1);
    expect_at(h + FC - 1, 5, 1, "R10");
    expect_at(h + FC, 5, 0, "R10");
    settle();
    set_fb(0, 1, 0, 1);
    expect_at(cyc + 1, 5, 1, "R8");
    settle();

    // Downward slew (R6)
    send_code(30, 1'b1, h);
    settle();

    // Restart of the window by a second code (R7)
    send_code(33, 1'b0, h1);
    repeat (4) @(negedge clk);
    send_code(45, 1'b0, h2);
    expect_at(h1 + FC, 4, 1, "R7");
    expect_at(h2 + FC - 1, 4, 1, "R7");
    expect_at(h2 + FC, 4, 0, "R7");
    expect_at(h2 + SL * 16, 0, 45, "R6");
    settle();

    // Disable in the middle of a window (R11)
    send_code(20, 1'b0, h);
    repeat (5) @(negedge clk);
    n = cyc;
    en = 1'b0;
    for (int s = 0; s < 7; s++) expect_at(n + 1, s, 0, "R11");
    repeat (3) @(negedge clk);
    n = cyc;
    en = 1'b1;
    expect_at(n + STEP - 1, 1, 0, "R11");
    expect_at(n + STEP, 1, 1, "R11");
    expect_at(n + STEP, 2, 0, "R11");
    expect_at(n + STEP, 0, 0, "R4");
    settle();
    finish_run();
  end

endmodule